// File: doc/BRIEF.md
# Per-Input Skew Alignment Delays

This block sits in front of a two-source video mixing datapath and realigns its five inputs: pixel A, pixel B, the mix weight, the rounding select and the number-format flag. Each of the five lines can be given its own extra latency of zero to seven clock cycles. This lets sources that reach the chip with different pipeline depths meet in the same cycle at the mixer core. The extra latency comes on top of the mixer's own fixed pipeline.

The five delay amounts are held in a single 15-bit configuration word. Software or a board controller sends it one bit at a time, least significant bit first, on a data pin. Each bit is taken on a rising edge of a separate load strobe. Both pins may be asynchronous to the pixel clock. They are brought into the clock domain and edge-detected, so the configuration register runs on the pixel clock. A bypass pin makes every line act as if its delay were zero, and leaves the stored word unchanged.

Top module: `skew_align`

## Requirements
- R1: Reset clears the configuration word and every delay stage. After reset, with no word loaded, each output equals its input in the same cycle.
- R2: Field positions in the configuration word: bits [2:0] delay pixel A, [5:3] delay pixel B, [8:6] delay the mix weight, [11:9] delay the rounding select, [14:12] delay the format flag.
- R3: A field value d, from 0 to 7 read as unsigned binary, makes that output equal the input from exactly d clock cycles earlier. A value of 0 passes the input through combinationally.
- R4: The word is shifted in least significant bit first, one data bit per rising edge of the load strobe, however long the strobe stays high. After 15 edges, the first bit sent sits in bit 0.
- R5: If more than 15 strobe edges are applied, the word holds the 15 most recent bits and the older bits are lost.
- R6: While bypass is high, every output equals its input in the same cycle, whatever word is stored. When bypass falls, the stored word applies again without any reload.
- R7: Each field controls only its own line. Setting one field leaves the timing of the other four lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_strobe | input | 1 | Serial load strobe, asynchronous; rising edge shifts one bit |
| ser_bit | input | 1 | Serial configuration data, asynchronous, held stable around strobe edges |
| bypass | input | 1 | Forces zero extra delay on all lines |
| a_in | input | PIX_W (12) | Pixel A in |
| b_in | input | PIX_W (12) | Pixel B in |
| m_in | input | MIX_W (12) | Mix weight in |
| rnd_in | input | RND_W (2) | Rounding select in |
| tc_in | input | 1 | Number-format flag in |
| a_out | output | PIX_W (12) | Realigned pixel A |
| b_out | output | PIX_W (12) | Realigned pixel B |
| m_out | output | MIX_W (12) | Realigned mix weight |
| rnd_out | output | RND_W (2) | Realigned rounding select |
| tc_out | output | 1 | Realigned format flag |

## Verification
All five lines are swept together through every delay from 0 to 7. This shows that the taps are correct and that LSB-first loading works. Words with different values in each field, a word in reverse order and a word with only one field set show that fields are placed correctly and that the lines do not affect each other; a swapped or shared field would shift the wrong line. An 18-bit load that begins with three junk ones tests that only the most recent 15 bits are kept. A bypass run on a fully loaded word, followed by release, shows both that bypass overrides the word and that the word is kept. Each stream feeds a different counter-derived value every cycle, so a delay that is off by even one cycle gives a mismatch.

// File: rtl/skew_pkg.sv
package skew_pkg;

    localparam int DLY_W   = 3;
    localparam int N_LINES = 5;
    localparam int CFG_W   = DLY_W * N_LINES;
    localparam int TAPS    = 1 << DLY_W;

    typedef logic [DLY_W-1:0] dly_t;

    // Packed MSB first, so pixel A lands in bits [2:0].
    typedef struct packed {
        dly_t tc;
        dly_t rnd;
        dly_t mix;
        dly_t pix_b;
        dly_t pix_a;
    } dly_cfg_t;

    function automatic dly_cfg_t effective_cfg(input dly_cfg_t stored, input logic force_zero);
        return force_zero ? '0 : stored;
    endfunction

    function automatic dly_cfg_t shift_in_lsb_first(input dly_cfg_t cur, input logic bit_in);
        logic [CFG_W-1:0] raw;
        raw = cur;
        return dly_cfg_t'({bit_in, raw[CFG_W-1:1]});
    endfunction

endpackage

// File: rtl/skew_serial_sync.sv
module skew_serial_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_async,
    input  logic dat_async,
    output logic ld_rise,
    output logic dat_bit
);
    logic [STAGES-1:0] ld_sh;
    logic [STAGES-1:0] dat_sh;
    logic              ld_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_sh   <= '0;
            dat_sh  <= '0;
            ld_prev <= 1'b0;
        end else begin
            ld_sh   <= {ld_sh[STAGES-2:0], ld_async};
            dat_sh  <= {dat_sh[STAGES-2:0], dat_async};
            ld_prev <= ld_sh[STAGES-1];
        end
    end

    assign ld_rise = ld_sh[STAGES-1] & ~ld_prev;
    assign dat_bit = dat_sh[STAGES-1];
endmodule

// File: rtl/skew_cfg_shift.sv
module skew_cfg_shift
    import skew_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  logic     bit_in,
    output dly_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (step) cfg <= shift_in_lsb_first(cfg, bit_in);
    end
endmodule

// File: rtl/skew_tap_line.sv
module skew_tap_line #(
    parameter int W    = 12,
    parameter int TAPS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(TAPS)-1:0] sel,
    input  logic [W-1:0]            din,
    output logic [W-1:0]            dout
);
    localparam int SEL_W = $clog2(TAPS);

    logic [W-1:0] stage [1:TAPS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < TAPS; k++) stage[k] <= '0;
        end else begin
            stage[1] <= din;
            for (int k = 2; k < TAPS; k++) stage[k] <= stage[k-1];
        end
    end

    always_comb begin
        dout = din;
        for (int k = 1; k < TAPS; k++)
            if (sel == SEL_W'(k)) dout = stage[k];
    end
endmodule

// File: rtl/skew_align.sv
module skew_align
    import skew_pkg::*;
#(
    parameter int PIX_W       = 12,
    parameter int MIX_W       = 12,
    parameter int RND_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_strobe,
    input  logic             ser_bit,
    input  logic             bypass,
    input  logic [PIX_W-1:0] a_in,
    input  logic [PIX_W-1:0] b_in,
    input  logic [MIX_W-1:0] m_in,
    input  logic [RND_W-1:0] rnd_in,
    input  logic             tc_in,
    output logic [PIX_W-1:0] a_out,
    output logic [PIX_W-1:0] b_out,
    output logic [MIX_W-1:0] m_out,
    output logic [RND_W-1:0] rnd_out,
    output logic             tc_out
);
    logic     ld_rise;
    logic     dat_bit;
    dly_cfg_t cfg_word;
    dly_cfg_t cfg_eff;

    skew_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ld_async(ld_strobe), .dat_async(ser_bit),
        .ld_rise(ld_rise), .dat_bit(dat_bit)
    );

    skew_cfg_shift u_cfg (
        .clk(clk), .rst(rst), .step(ld_rise), .bit_in(dat_bit), .cfg(cfg_word)
    );

    assign cfg_eff = effective_cfg(cfg_word, bypass);

    skew_tap_line #(.W(PIX_W), .TAPS(TAPS)) u_line_a (
        .clk(clk), .rst(rst), .sel(cfg_eff.pix_a), .din(a_in), .dout(a_out)
    );
    skew_tap_line #(.W(PIX_W), .TAPS(TAPS)) u_line_b (
        .clk(clk), .rst(rst), .sel(cfg_eff.pix_b), .din(b_in), .dout(b_out)
    );
    skew_tap_line #(.W(MIX_W), .TAPS(TAPS)) u_line_m (
        .clk(clk), .rst(rst), .sel(cfg_eff.mix), .din(m_in), .dout(m_out)
    );
    skew_tap_line #(.W(RND_W), .TAPS(TAPS)) u_line_r (
        .clk(clk), .rst(rst), .sel(cfg_eff.rnd), .din(rnd_in), .dout(rnd_out)
    );
    skew_tap_line #(.W(1), .TAPS(TAPS)) u_line_t (
        .clk(clk), .rst(rst), .sel(cfg_eff.tc), .din(tc_in), .dout(tc_out)
    );
endmodule

// File: rtl/skew_align_chk.sv
module skew_align_chk #(
    parameter int PIX_W = 12,
    parameter int MIX_W = 12,
    parameter int RND_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bypass,
    input logic [14:0]      cfg_word,
    input logic             ld_rise,
    input logic [PIX_W-1:0] a_in,
    input logic [PIX_W-1:0] a_out,
    input logic [MIX_W-1:0] m_in,
    input logic [MIX_W-1:0] m_out,
    input logic [RND_W-1:0] rnd_in,
    input logic [RND_W-1:0] rnd_out,
    input logic             tc_in,
    input logic             tc_out
);
    a_r1_word_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_word == 15'd0);

    a_r4_word_moves_on_edge: assert property (@(posedge clk) disable iff (rst)
        !ld_rise |=> $stable(cfg_word));

    a_r6_bypass_passthru: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (a_out == a_in && m_out == m_in && rnd_out == rnd_in && tc_out == tc_in));

    a_r3_zero_tap: assert property (@(posedge clk) disable iff (rst)
        (!bypass && cfg_word[2:0] == 3'd0) |-> a_out == a_in);

    a_r2_mix_field: assert property (@(posedge clk) disable iff (rst)
        (!bypass && cfg_word[8:6] == 3'd0) |-> m_out == m_in);

    a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (!bypass && cfg_word[14:12] == 3'd1 && !$past(rst)) |-> tc_out == $past(tc_in));
endmodule

bind skew_align skew_align_chk #(.PIX_W(PIX_W), .MIX_W(MIX_W), .RND_W(RND_W)) u_chk (
    .clk(clk), .rst(rst), .bypass(bypass), .cfg_word(cfg_word), .ld_rise(ld_rise),
    .a_in(a_in), .a_out(a_out), .m_in(m_in), .m_out(m_out),
    .rnd_in(rnd_in), .rnd_out(rnd_out), .tc_in(tc_in), .tc_out(tc_out)
);

// File: tb/tb_skew_align.sv
module tb_skew_align;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_strobe = 1'b0;
    logic        ser_bit = 1'b0;
    logic        bypass = 1'b0;
    logic [11:0] a_in = '0, b_in = '0, m_in = '0;
    logic [1:0]  rnd_in = '0;
    logic        tc_in = 1'b0;
    logic [11:0] a_out, b_out, m_out;
    logic [1:0]  rnd_out;
    logic        tc_out;

    int total = 0;
    int bad = 0;
    int seq = 0;

    logic [11:0] ha [0:7];
    logic [11:0] hb [0:7];
    logic [11:0] hm [0:7];
    logic [1:0]  hr [0:7];
    logic        ht [0:7];

    always #10 clk = ~clk;

    skew_align dut (
        .clk(clk), .rst(rst), .ld_strobe(ld_strobe), .ser_bit(ser_bit), .bypass(bypass),
        .a_in(a_in), .b_in(b_in), .m_in(m_in), .rnd_in(rnd_in), .tc_in(tc_in),
        .a_out(a_out), .b_out(b_out), .m_out(m_out), .rnd_out(rnd_out), .tc_out(tc_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_bit = b;
        repeat (3) @(negedge clk);
        ld_strobe = 1'b1;
        repeat (4) @(negedge clk);
        ld_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_word(input logic [14:0] w, input int junk);
        for (int i = 0; i < junk; i++) send_bit(1'b1);
        for (int i = 0; i < 15; i++) send_bit(w[i]);
    endtask

    // w is the effective word the bench expects; fields per R2.
    task automatic run_stream(input logic [14:0] w, input int nchk, input string req);
        int da, db, dm, dr, dt;
        da = int'(w[2:0]);  db = int'(w[5:3]);  dm = int'(w[8:6]);
        dr = int'(w[11:9]); dt = int'(w[14:12]);
        for (int s = 0; s < 8 + nchk; s++) begin
            @(negedge clk);
            a_in   = 12'(seq * 149 + 3);
            b_in   = 12'(seq * 71) ^ 12'h5a3;
            m_in   = 12'(seq * 29 + 7);
            rnd_in = 2'(seq ^ (seq >> 3));
            tc_in  = 1'(seq ^ (seq >> 2));
            for (int k = 7; k > 0; k--) begin
                ha[k] = ha[k-1]; hb[k] = hb[k-1]; hm[k] = hm[k-1];
                hr[k] = hr[k-1]; ht[k] = ht[k-1];
            end
            ha[0] = a_in; hb[0] = b_in; hm[0] = m_in; hr[0] = rnd_in; ht[0] = tc_in;
            seq++;
            #1;
            if (s >= 8) begin
                chk(a_out == ha[da],   {req, " line A"},   int'(a_out),   int'(ha[da]));
                chk(b_out == hb[db],   {req, " line B"},   int'(b_out),   int'(hb[db]));
                chk(m_out == hm[dm],   {req, " line M"},   int'(m_out),   int'(hm[dm]));
                chk(rnd_out == hr[dr], {req, " line RND"}, int'(rnd_out), int'(hr[dr]));
                chk(tc_out == ht[dt],  {req, " line TC"},  int'(tc_out),  int'(ht[dt]));
            end
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check_passthru(input string req);
        @(negedge clk);
        a_in = 12'h9c3; b_in = 12'h1e7; m_in = 12'h800; rnd_in = 2'd2; tc_in = 1'b1;
        #1;
        chk(a_out == a_in && b_out == b_in && m_out == m_in && rnd_out == rnd_in && tc_out == tc_in,
            req, int'({a_out, tc_out}), int'({a_in, tc_in}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state gives combinational pass-through
        check_passthru("R1 reset pass-through");

        // R3, R4: every delay 0..7 on all lines together
        for (int d = 0; d < 8; d++) begin
            logic [2:0] f;
            f = 3'(d);
            load_word({f, f, f, f, f}, 0);
            run_stream({f, f, f, f, f}, 10, "R3 R4 uniform delay");
        end

        // R2, R7: distinct and isolated fields
        load_word({3'd5, 3'd4, 3'd3, 3'd2, 3'd1}, 0);
        run_stream({3'd5, 3'd4, 3'd3, 3'd2, 3'd1}, 10, "R2 distinct fields");
        load_word({3'd1, 3'd2, 3'd3, 3'd4, 3'd5}, 0);
        run_stream({3'd1, 3'd2, 3'd3, 3'd4, 3'd5}, 10, "R2 reversed fields");
        load_word({3'd7, 3'd0, 3'd7, 3'd0, 3'd7}, 0);
        run_stream({3'd7, 3'd0, 3'd7, 3'd0, 3'd7}, 10, "R7 alternating fields");
        load_word({3'd0, 3'd0, 3'd6, 3'd0, 3'd0}, 0);
        run_stream({3'd0, 3'd0, 3'd6, 3'd0, 3'd0}, 10, "R7 single field");

        // R5: three junk ones before the word
        load_word({3'd2, 3'd6, 3'd0, 3'd3, 3'd4}, 3);
        run_stream({3'd2, 3'd6, 3'd0, 3'd3, 3'd4}, 10, "R5 overlong load");

        // R6: bypass overrides, word retained
        load_word({3'd7, 3'd6, 3'd5, 3'd4, 3'd3}, 0);
        @(negedge clk); bypass = 1'b1;
        run_stream(15'd0, 10, "R6 bypass zero delay");
        @(negedge clk); bypass = 1'b0;
        run_stream({3'd7, 3'd6, 3'd5, 3'd4, 3'd3}, 10, "R6 word kept after bypass");

        // R1: reset after a loaded word clears it
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_passthru("R1 reset clears word");
        run_stream(15'd0, 6, "R1 zero delay after reset");

        finish_run();
    end
endmodule